// File: doc/BRIEF.md
# Shared Memory Cell Allocator

This block picks a memory bank for every fixed-size cell that enters a shared-memory switch built from NB = 3·N single-access banks. Each bank can do one access per time slot. Cells of one slot are presented one per clock cycle. Each cell brings its departure slot, given as a delay in slots from the current slot. For each cell the allocator returns a bank that meets three conditions. No earlier cell of this slot was written to it. It is not read in this slot. It is not already booked for a read in the cell's departure slot. The allocator then books that bank for the departure slot, so the read side knows which bank to fetch from.

The bookings sit in a circular table with one row of NB bits per slot, indexed by slot number modulo a power-of-two horizon. A slot-start pulse moves the current slot forward. It also empties the row of the slot just consumed and clears the mask of banks written in the slot. The input and output port numbers of a cell play no part in the bank choice, so they are not inputs to the block.

Top module: `cell_bank_alloc`

## Requirements
- R1: After reset, grant_valid and grant_err are 0, the current slot is 0, and no bank is marked written or booked.
- R2: A request accepted at a clock edge produces a result at the next edge: either grant_valid=1 with grant_bank equal to the lowest-numbered bank that is free, or grant_err=1. The two flags are never 1 together.
- R3: A bank granted to an earlier cell of the current slot is not granted again in that slot.
- R4: A bank booked for a read in the current slot is not granted.
- R5: A bank booked for a read in slot (current + req_delay) mod HORIZON is not granted. Each grant books its bank in that slot.
- R6: A slot_start pulse advances the current slot by one, modulo HORIZON. It clears the written-in-slot mask and empties the booking row of the slot that was just current.
- R7: When no bank is free, the result is grant_err=1 and no mask or booking changes.
- R8: A request with req_delay = 0 gives grant_err=1 and changes nothing.
- R9: A request presented in the same cycle as slot_start is ignored. It gives neither a grant nor an error, and it books nothing.
- R10: With at most N cells per slot and at most N bookings per departure slot, no request ever gives an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Advance to the next time slot |
| req_valid | input | 1 | A cell needs a bank this cycle |
| req_delay | input | $clog2(HORIZON) | Departure slot minus current slot |
| grant_valid | output | 1 | grant_bank holds the chosen bank |
| grant_err | output | 1 | No bank could be assigned |
| grant_bank | output | $clog2(3*NPORTS) | Chosen bank index |

## Verification
The hardest condition to reach from the ports is a booking row that has been consumed and cleared, then reused when the slot counter wraps around the horizon. No port shows the table. The stimulus books bank 0 for slot 1 and steps the slot past 1. It then asks for a delay that wraps back onto row 1. Bank 0 is expected only if the row was cleared. An error that must leave no trace is handled the same way. The stimulus fills every bank in one slot and issues one more request aimed at a later row. When that row becomes the current read set, the stimulus checks that bank 0 is still free in it.

// File: rtl/cell_bank_alloc.sv
module cell_bank_alloc #(
  parameter int NPORTS  = 4,
  parameter int HORIZON = 16,
  localparam int NB     = 3 * NPORTS,
  localparam int SLOT_W = $clog2(HORIZON),
  localparam int BANK_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_delay,
  output logic              grant_valid,
  output logic              grant_err,
  output logic [BANK_W-1:0] grant_bank
);

  logic [NB-1:0]     wbusy;
  logic [NB-1:0]     resv [HORIZON];
  logic [SLOT_W-1:0] cur;
  logic [SLOT_W-1:0] dt_idx;
  logic [NB-1:0]     free;
  logic [BANK_W-1:0] pick;
  logic              take, bad;

  assign dt_idx = cur + req_delay;
  assign free   = ~(wbusy | resv[cur] | resv[dt_idx]);
  assign bad    = (req_delay == '0) || (free == '0);
  assign take   = req_valid && !slot_start;

  always_comb begin
    pick = '0;
    for (int b = NB - 1; b >= 0; b--)
      if (free[b]) pick = BANK_W'(b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbusy       <= '0;
      cur         <= '0;
      grant_valid <= 1'b0;
      grant_err   <= 1'b0;
      grant_bank  <= '0;
      for (int s = 0; s < HORIZON; s++) resv[s] <= '0;
    end else begin
      grant_valid <= take && !bad;
      grant_err   <= take && bad;
      grant_bank  <= (take && !bad) ? pick : '0;
      if (slot_start) begin
        wbusy     <= '0;
        resv[cur] <= '0;
        cur       <= cur + 1'b1;
      end else if (take && !bad) begin
        wbusy[pick]        <= 1'b1;
        resv[dt_idx][pick] <= 1'b1;
      end
    end
  end

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && grant_err));

  p_distinct_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && $past(grant_valid) && !$past(slot_start)) |-> grant_bank != $past(grant_bank));

  p_err_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_err |-> wbusy == $past(wbusy));

  p_zero_delay_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !slot_start && req_delay == '0) |=> grant_err);

  p_ignore_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !grant_valid && !grant_err);

endmodule

// File: tb/cell_bank_alloc_tb_top.sv
module cell_bank_alloc_tb_top;
  localparam int NPORTS = 4;
  localparam int HORIZON = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_start = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_delay = '0;
  logic       grant_valid, grant_err;
  logic [3:0] grant_bank;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cell_bank_alloc #(.NPORTS(NPORTS), .HORIZON(HORIZON)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .req_valid(req_valid),
    .req_delay(req_delay), .grant_valid(grant_valid), .grant_err(grant_err),
    .grant_bank(grant_bank));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_start = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic next_slot();
    @(negedge clk);
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
  endtask

  task automatic issue(input int d, output logic v, output logic e, output int b);
    @(negedge clk);
    req_valid = 1'b1; req_delay = 4'(d);
    @(negedge clk);
    req_valid = 1'b0;
    v = grant_valid; e = grant_err; b = int'(grant_bank);
  endtask

  task automatic expect_bank(input string req, input int d, input int bank);
    logic v, e; int b;
    issue(d, v, e, b);
    chk({req, " valid"}, int'(v), 1);
    chk({req, " bank"}, b, bank);
  endtask

  task automatic expect_err(input string req, input int d);
    logic v, e; int b;
    issue(d, v, e, b);
    chk({req, " err"}, int'(e), 1);
    chk({req, " valid"}, int'(v), 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 valid after reset", int'(grant_valid), 0);
    chk("R1 err after reset", int'(grant_err), 0);
    expect_bank("R1 empty tables", 3, 0);
  endtask

  task automatic t_main();
    do_reset();
    expect_bank("R3 first", 1, 0);
    expect_bank("R3 second", 2, 1);
    expect_bank("R3 third", 3, 2);
    expect_bank("R3 fourth", 4, 3);
    next_slot();
    expect_bank("R4 R6 skip read bank0", 2, 1);
    expect_bank("R5 skip bank2 booked", 2, 3);
    next_slot();
    expect_bank("R5 dt conflict", 2, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    expect_bank("R6 book row1", 1, 0);
    next_slot();
    next_slot();
    expect_bank("R6 row cleared on wrap", 15, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 3 * NPORTS; k++) expect_bank("R2 fill", 1, k);
    expect_err("R7 no free bank", 2);
    next_slot();
    next_slot();
    expect_bank("R7 no booking left", 1, 0);
    expect_err("R8 zero delay", 0);
    @(negedge clk);
    slot_start = 1'b1; req_valid = 1'b1; req_delay = 4'd1;
    @(negedge clk);
    slot_start = 1'b0; req_valid = 1'b0;
    chk("R9 no grant", int'(grant_valid), 0);
    chk("R9 no err", int'(grant_err), 0);
    expect_bank("R9 nothing booked", 1, 1);
  endtask

  task automatic t_load();
    logic v, e; int b;
    do_reset();
    for (int s = 0; s < 20; s++) begin
      for (int k = 0; k < NPORTS; k++) begin
        issue(k + 1, v, e, b);
        chk("R10 no error", int'(e), 0);
        chk("R10 valid", int'(v), 1);
      end
      next_slot();
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_main();
        t_wrap();
        t_full();
        t_load();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule